// File: doc/BRIEF.md
# Isochronous Data Block Unpacker

This block sits on the receive side of an isochronous audio path. It takes a stream of 32-bit quadlets, grouped into data blocks by a start-of-block marker, and splits each block into per-channel audio samples and an optional MIDI quadlet. Each block can begin with a configurable run of quadlets that are thrown away. Those are followed by one quadlet per audio channel and then, only when MIDI ports are configured, a single MIDI quadlet.

The quadlets arrive big-endian. A byte-swap control reverses the byte order of each quadlet before it is presented. Configuration is captured on the start-of-block beat and held for the rest of the block, so software can change it at any time without tearing a block. Surplus quadlets raise an overflow pulse. A block cut short by an early start marker raises a short-block pulse.

Top module: `iso_block_unpacker`

## Requirements
- R1: The first `cfg_skip_i` quadlets of a block, counting the start-of-block quadlet as position 0, produce no audio, MIDI or overflow output.
- R2: With A audio channels, positions skip to skip+A-1 appear on `aud_data_o`, with `aud_valid_o` high and `aud_chan_o` running from 0 to A-1 in order, one cycle after the quadlet is accepted.
- R3: When `cfg_midi_i` is nonzero, the quadlet at position skip+A appears on `midi_data_o` with `midi_valid_o` high, one cycle after it is accepted.
- R4: When `cfg_midi_i` is zero, position skip+A is not a MIDI quadlet. It is treated as surplus.
- R5: When `cfg_swap_i` is high on the accepting beat, the output quadlet has byte 3 and byte 0 exchanged and byte 2 and byte 1 exchanged. When it is low, the quadlet passes unchanged. The byte-swap control takes effect per quadlet.
- R6: Each quadlet beyond the block length (skip + A + (midi nonzero ? 1 : 0)) and before the next start marker is dropped. For each one, `overflow_o` is high for one cycle. Overflow never coincides with an audio or MIDI output.
- R7: A start marker accepted while the current block has fewer quadlets than its length raises `short_o` for one cycle. The marker quadlet becomes position 0 of the new block.
- R8: Skip, audio count and MIDI count are sampled only on the start-of-block beat. Changes on later beats of the same block have no effect.
- R9: Nothing is accepted while `in_valid_i` is low. Quadlets accepted after reset but before the first start marker produce no output and no flag.
- R10: While reset is applied, every output strobe, flag and `in_ready_o` is low. `in_ready_o` is high from the first clock edge after reset release onward and stays high.
- R11: An audio count above MAX_AUDIO (8 by default) is treated as MAX_AUDIO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input quadlet valid |
| in_ready_o | output | 1 | Input accept |
| in_sob_i | input | 1 | Quadlet is the first of a data block |
| in_data_i | input | 32 | Input quadlet, bus byte order |
| cfg_skip_i | input | SKIP_W (3) | Leading quadlets to drop per block |
| cfg_audio_i | input | CNT_W (4) | Audio channel count |
| cfg_midi_i | input | MIDI_W (4) | MIDI port count, 0 to 8 |
| cfg_swap_i | input | 1 | Reverse byte order per quadlet |
| aud_valid_o | output | 1 | Audio sample strobe |
| aud_chan_o | output | CH_W (3) | Audio channel index |
| aud_data_o | output | 32 | Audio sample quadlet |
| midi_valid_o | output | 1 | MIDI quadlet strobe |
| midi_data_o | output | 32 | MIDI quadlet |
| overflow_o | output | 1 | Surplus quadlet dropped |
| short_o | output | 1 | Block ended early by a start marker |

## Verification
The hardest situation to reach is a block cut short when the configuration presented on the interrupting start beat differs from the one held for the truncated block. The short test must be judged against the old length, while the new block must follow the new settings from its first quadlet. The bench walks a sweep of skip, channel count and MIDI settings, varying the length of each block across exact, one surplus, two surplus and one missing. It also drives deliberately scrambled configuration values on every beat that is not a start beat. This means every truncation lands on a configuration change, and every mid-block change of the inputs is shown to have no effect.

// File: rtl/unpk_pkg.sv
package unpk_pkg;
  typedef enum logic [1:0] {K_DROP, K_AUDIO, K_MIDI, K_EXCESS} beat_kind_e;

  function automatic logic [31:0] swap32(input logic [31:0] q);
    return {q[7:0], q[15:8], q[23:16], q[31:24]};
  endfunction
endpackage

// File: rtl/unpk_cfg_hold.sv
module unpk_cfg_hold #(
  parameter int SKIP_W    = 3,
  parameter int MAX_AUDIO = 8,
  parameter int MIDI_W    = 4,
  localparam int CNT_W    = $clog2(MAX_AUDIO + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [SKIP_W-1:0] skip_i,
  input  logic [CNT_W-1:0]  audio_i,
  input  logic [MIDI_W-1:0] midi_i,
  output logic [SKIP_W-1:0] skip_o,
  output logic [CNT_W-1:0]  audio_o,
  output logic              midi_en_o
);
  logic [SKIP_W-1:0] skip_q;
  logic [CNT_W-1:0]  audio_q, audio_c;
  logic              midi_q;

  assign audio_c = (audio_i > CNT_W'(MAX_AUDIO)) ? CNT_W'(MAX_AUDIO) : audio_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      skip_q  <= '0;
      audio_q <= '0;
      midi_q  <= 1'b0;
    end else if (take_i) begin
      skip_q  <= skip_i;
      audio_q <= audio_c;
      midi_q  <= |midi_i;
    end
  end

  // start beat uses the live values, later beats the held ones
  assign skip_o    = take_i ? skip_i  : skip_q;
  assign audio_o   = take_i ? audio_c : audio_q;
  assign midi_en_o = take_i ? |midi_i : midi_q;
endmodule

// File: rtl/unpk_pos_track.sv
module unpk_pos_track #(
  parameter int POS_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             beat_i,
  input  logic             sob_i,
  input  logic [POS_W-1:0] len_i,
  output logic [POS_W-1:0] pos_o,
  output logic             active_o,
  output logic             short_o
);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [POS_W-1:0] pos_q, len_q;
  logic             in_blk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q    <= '0;
      len_q    <= '0;
      in_blk_q <= 1'b0;
    end else if (beat_i) begin
      if (sob_i) begin
        pos_q    <= POS_W'(1);
        len_q    <= len_i;
        in_blk_q <= 1'b1;
      end else if (in_blk_q && pos_q != POS_MAX) begin
        pos_q <= pos_q + POS_W'(1);
      end
    end
  end

  assign pos_o    = sob_i ? '0 : pos_q;
  assign active_o = sob_i | in_blk_q;
  assign short_o  = beat_i & sob_i & in_blk_q & (pos_q < len_q);
endmodule

// File: rtl/unpk_classify.sv
module unpk_classify
  import unpk_pkg::*;
#(
  parameter int SKIP_W = 3,
  parameter int CNT_W  = 4,
  parameter int POS_W  = 5,
  parameter int CH_W   = 3
) (
  input  logic [POS_W-1:0]  pos_i,
  input  logic              active_i,
  input  logic [SKIP_W-1:0] skip_i,
  input  logic [CNT_W-1:0]  audio_i,
  input  logic              midi_en_i,
  output beat_kind_e        kind_o,
  output logic [CH_W-1:0]   chan_o
);
  logic [POS_W-1:0] skip_w, audio_end, rel;

  assign skip_w    = POS_W'(skip_i);
  assign audio_end = skip_w + POS_W'(audio_i);
  assign rel       = pos_i - skip_w;
  assign chan_o    = rel[CH_W-1:0];

  always_comb begin
    if (!active_i)                      kind_o = K_DROP;
    else if (pos_i < skip_w)            kind_o = K_DROP;
    else if (pos_i < audio_end)         kind_o = K_AUDIO;
    else if (pos_i == audio_end && midi_en_i) kind_o = K_MIDI;
    else                                kind_o = K_EXCESS;
  end
endmodule

// File: rtl/iso_block_unpacker.sv
module iso_block_unpacker
  import unpk_pkg::*;
#(
  parameter int SKIP_W    = 3,
  parameter int MAX_AUDIO = 8,
  parameter int MIDI_W    = 4,
  localparam int CNT_W    = $clog2(MAX_AUDIO + 1),
  localparam int CH_W     = (MAX_AUDIO > 1) ? $clog2(MAX_AUDIO) : 1,
  localparam int MAX_SKIP = (1 << SKIP_W) - 1,
  localparam int POS_W    = $clog2(MAX_SKIP + MAX_AUDIO + 3)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic              in_sob_i,
  input  logic [31:0]       in_data_i,
  input  logic [SKIP_W-1:0] cfg_skip_i,
  input  logic [CNT_W-1:0]  cfg_audio_i,
  input  logic [MIDI_W-1:0] cfg_midi_i,
  input  logic              cfg_swap_i,
  output logic              aud_valid_o,
  output logic [CH_W-1:0]   aud_chan_o,
  output logic [31:0]       aud_data_o,
  output logic              midi_valid_o,
  output logic [31:0]       midi_data_o,
  output logic              overflow_o,
  output logic              short_o
);
  logic              ready_q, beat;
  logic [SKIP_W-1:0] skip_c;
  logic [CNT_W-1:0]  audio_c;
  logic              midi_en_c, active, short_c;
  logic [POS_W-1:0]  pos, len_c;
  beat_kind_e        kind;
  logic [CH_W-1:0]   chan;

  logic              aud_v_q, midi_v_q, ovf_q, short_q;
  logic [CH_W-1:0]   chan_q;
  logic [31:0]       data_q;

  assign beat  = in_valid_i & ready_q;
  assign len_c = POS_W'(skip_c) + POS_W'(audio_c) + POS_W'(midi_en_c);

  unpk_cfg_hold #(
    .SKIP_W(SKIP_W), .MAX_AUDIO(MAX_AUDIO), .MIDI_W(MIDI_W)
  ) u_cfg (
    .clk_i, .rst_ni,
    .take_i   (beat & in_sob_i),
    .skip_i   (cfg_skip_i),
    .audio_i  (cfg_audio_i),
    .midi_i   (cfg_midi_i),
    .skip_o   (skip_c),
    .audio_o  (audio_c),
    .midi_en_o(midi_en_c)
  );

  unpk_pos_track #(.POS_W(POS_W)) u_pos (
    .clk_i, .rst_ni,
    .beat_i  (beat),
    .sob_i   (in_sob_i),
    .len_i   (len_c),
    .pos_o   (pos),
    .active_o(active),
    .short_o (short_c)
  );

  unpk_classify #(
    .SKIP_W(SKIP_W), .CNT_W(CNT_W), .POS_W(POS_W), .CH_W(CH_W)
  ) u_cls (
    .pos_i    (pos),
    .active_i (active),
    .skip_i   (skip_c),
    .audio_i  (audio_c),
    .midi_en_i(midi_en_c),
    .kind_o   (kind),
    .chan_o   (chan)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q  <= 1'b0;
      aud_v_q  <= 1'b0;
      midi_v_q <= 1'b0;
      ovf_q    <= 1'b0;
      short_q  <= 1'b0;
      chan_q   <= '0;
      data_q   <= '0;
    end else begin
      ready_q  <= 1'b1;
      aud_v_q  <= beat && kind == K_AUDIO;
      midi_v_q <= beat && kind == K_MIDI;
      ovf_q    <= beat && kind == K_EXCESS;
      short_q  <= short_c;
      if (beat && kind == K_AUDIO) chan_q <= chan;
      if (beat && (kind == K_AUDIO || kind == K_MIDI))
        data_q <= cfg_swap_i ? swap32(in_data_i) : in_data_i;
    end
  end

  assign in_ready_o   = ready_q;
  assign aud_valid_o  = aud_v_q;
  assign aud_chan_o   = chan_q;
  assign aud_data_o   = data_q;
  assign midi_valid_o = midi_v_q;
  assign midi_data_o  = data_q;
  assign overflow_o   = ovf_q;
  assign short_o      = short_q;
endmodule

// File: rtl/unpk_chk.sv
module unpk_chk #(
  parameter int SKIP_W = 3,
  parameter int CNT_W  = 4,
  parameter int MIDI_W = 4,
  parameter int CH_W   = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              in_sob_i,
  input logic [31:0]       in_data_i,
  input logic [SKIP_W-1:0] cfg_skip_i,
  input logic [MIDI_W-1:0] cfg_midi_i,
  input logic              cfg_swap_i,
  input logic              aud_valid_o,
  input logic [CH_W-1:0]   aud_chan_o,
  input logic [31:0]       aud_data_o,
  input logic              midi_valid_o,
  input logic              overflow_o,
  input logic              short_o
);
  p_start_chan0_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aud_valid_o && $past(in_sob_i) |-> $past(cfg_skip_i) == '0 && aud_chan_o == '0);

  p_out_needs_beat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aud_valid_o || midi_valid_o || overflow_o) |-> $past(in_valid_i && in_ready_o));

  p_midi_needs_ports_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    midi_valid_o && $past(in_sob_i) |-> $past(cfg_midi_i) != '0);

  p_swap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aud_valid_o |-> aud_data_o == ($past(cfg_swap_i)
      ? {$past(in_data_i[7:0]), $past(in_data_i[15:8]),
         $past(in_data_i[23:16]), $past(in_data_i[31:24])}
      : $past(in_data_i)));

  p_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({aud_valid_o, midi_valid_o, overflow_o}));

  p_short_on_sob_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_o |-> $past(in_valid_i && in_sob_i));

  p_ready_stays_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(in_ready_o) |-> in_ready_o);
endmodule

bind iso_block_unpacker unpk_chk #(
  .SKIP_W(SKIP_W), .CNT_W(CNT_W), .MIDI_W(MIDI_W), .CH_W(CH_W)
) u_chk (
  .clk_i, .rst_ni, .in_valid_i, .in_ready_o, .in_sob_i, .in_data_i,
  .cfg_skip_i, .cfg_midi_i, .cfg_swap_i, .aud_valid_o, .aud_chan_o,
  .aud_data_o, .midi_valid_o, .overflow_o, .short_o
);

// File: tb/tb_iso_block_unpacker.sv
module tb_iso_block_unpacker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sob = 1'b0, swap = 1'b0;
  logic [31:0] in_data = '0;
  logic [2:0]  skip = '0;
  logic [3:0]  audio = '0, midi = '0;
  logic        in_ready, aud_valid, midi_valid, overflow, short_f;
  logic [2:0]  aud_chan;
  logic [31:0] aud_data, midi_data;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  iso_block_unpacker dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_sob_i(in_sob), .in_data_i(in_data), .cfg_skip_i(skip),
    .cfg_audio_i(audio), .cfg_midi_i(midi), .cfg_swap_i(swap),
    .aud_valid_o(aud_valid), .aud_chan_o(aud_chan), .aud_data_o(aud_data),
    .midi_valid_o(midi_valid), .midi_data_o(midi_data),
    .overflow_o(overflow), .short_o(short_f)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] bswap(input logic [31:0] q);
    return {q[7:0], q[15:8], q[23:16], q[31:24]};
  endfunction

  // 0 drop, 1 audio, 2 midi, 3 surplus
  function automatic int kind_of(int p, int s, int a, int m);
    if (p < s) return 0;
    if (p < s + a) return 1;
    if (p == s + a && m != 0) return 2;
    return 3;
  endfunction

  task automatic idle_beat();
    @(negedge clk);
    in_valid = 1'b0; in_sob = 1'b1; in_data = 32'hDEAD_BEEF;
    @(posedge clk); #1;
    chk(!aud_valid && !midi_valid && !overflow && !short_f, "R9", "idle outputs",
        {28'd0, aud_valid, midi_valid, overflow, short_f}, 32'd0);
    in_sob = 1'b0;
  endtask

  task automatic beat(input bit sob, input logic [31:0] d, input bit sw,
                      input logic [2:0] s, input logic [3:0] a, input logic [3:0] m,
                      input int k, input int ch, input bit exp_short, input string req);
    logic [31:0] ed;
    @(negedge clk);
    in_valid = 1'b1; in_sob = sob; in_data = d; swap = sw;
    // R8: off-boundary beats carry scrambled configuration
    if (sob) begin skip = s; audio = a; midi = m; end
    else begin skip = s ^ 3'b101; audio = a ^ 4'b0110; midi = (m == 0) ? 4'd5 : 4'd0; end
    @(posedge clk); #1;
    in_valid = 1'b0;
    ed = sw ? bswap(d) : d;
    chk(aud_valid == (k == 1), req, "aud_valid", 32'(aud_valid), 32'(k == 1));
    chk(midi_valid == (k == 2), req, "midi_valid", 32'(midi_valid), 32'(k == 2));
    chk(overflow == (k == 3), req, "overflow", 32'(overflow), 32'(k == 3));
    chk(short_f == exp_short, "R7", "short", 32'(short_f), 32'(exp_short));
    if (k == 1) begin
      chk(aud_chan == 3'(ch), req, "aud_chan", 32'(aud_chan), 32'(ch));
      chk(aud_data == ed, (sw ? "R5" : req), "aud_data", aud_data, ed);
    end
    if (k == 2) chk(midi_data == ed, (sw ? "R5" : "R3"), "midi_data", midi_data, ed);
  endtask

  initial begin
    bit pending = 0;
    int blk = 0;
    #1;
    chk(!in_ready && !aud_valid && !midi_valid && !overflow && !short_f, "R10",
        "reset outputs", {27'd0, in_ready, aud_valid, midi_valid, overflow, short_f}, 32'd0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk(in_ready == 1'b1, "R10", "ready after reset", 32'(in_ready), 32'd1);

    // R9: accepted quadlets before any start marker vanish
    for (int i = 0; i < 3; i++)
      beat(1'b0, 32'h1111_0000 + 32'(i), 1'b0, 3'd0, 4'd2, 4'd1, 0, 0, 1'b0, "R9");

    for (int s = 0; s < 4; s++)
      for (int ai = 0; ai < 10; ai++)
        for (int mi = 0; mi < 2; mi++) begin
          int acfg = (ai == 9) ? 15 : ai;
          int aeff = (acfg > 8) ? 8 : acfg;
          int m = mi * 3;
          int len = s + aeff + ((m != 0) ? 1 : 0);
          int mode = blk % 4;
          int n = (mode == 0) ? len : (mode == 1) ? len + 1 : (mode == 2) ? len + 2 :
                  ((len > 1) ? len - 1 : len + 1);
          for (int p = 0; p < n; p++) begin
            int k = kind_of(p, s, aeff, m);
            string req;
            logic [31:0] d = {8'(p + 16), 8'(blk), 8'(s * 16 + ai), 8'hC3};
            if (k == 0) req = "R1";
            else if (k == 1) req = (ai == 9) ? "R11" : "R2";
            else if (k == 2) req = "R3";
            else req = (p == s + aeff && m == 0) ? "R4" : "R6";
            if (p == 1 && blk % 5 == 0) idle_beat();
            beat(p == 0, d, 1'((p + blk) % 2), 3'(s), 4'(acfg), 4'(m), k, p - s,
                 (p == 0) && pending, req);
          end
          pending = (n < len);
          blk++;
        end
    // closing block exposes the last pending truncation
    beat(1'b1, 32'hA5A5_0001, 1'b0, 3'd0, 4'd1, 4'd0, 1, 0, pending, "R2");
    beat(1'b0, 32'hA5A5_0002, 1'b1, 3'd0, 4'd1, 4'd0, 3, 0, 1'b0, "R6");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule